// File: doc/BRIEF.md
# UART Receive FIFO with Per-Character Error Tracking

This block is the receive queue of a 16x-oversampled UART. A deserializer hands it one character at a time through a strobe. With each character come three flags: parity error, framing error and break. Each byte is stored together with its own flags. The flags of a character become visible to the host only while that character sits at the head of the queue. A separate summary output stays high while any stored character carries an error.

The host drains the queue through a receive-buffer read strobe. It watches data-ready, overrun, the head error flags, the occupancy count and a trigger-reached output. That output compares the occupancy against one of four programmable thresholds. A control-word write sets the threshold, enables or disables queue mode, clears the receive queue, and emits a one-cycle flush request to the transmit path. A line-status read strobe acknowledges overrun and the head error flags.

Top module: `uart_rx_err_fifo`

## Requirements
- R1: With queue mode enabled, up to 16 characters are held in arrival order, and `level` reports how many are stored.
- R2: A character strobed while the queue is full and no read occurs in the same cycle is discarded and sets `overrun`. Stored entries are unchanged. A strobe in the same cycle as a read of a full queue is accepted.
- R3: A control write with bit 1 set empties the receive queue and drops any character strobed in that cycle. A control write with bit 2 set raises `tx_flush` for exactly one cycle and leaves the receive queue untouched. A write that changes bit 0 also empties the receive queue.
- R4: While the queue is empty, `rbr_q` reads 0x00 and `data_ready` is low. A read strobe on an empty queue changes nothing.
- R5: `head_break`, `head_frm_err` and `head_par_err` show the flags of the head character only. After a read they show the flags of the new head.
- R6: `err_in_fifo` is high while at least one stored character has any flag set, and low once none remains.
- R7: A character strobed with the break flag is stored as data 0x00 with the framing flag forced on. Its parity flag is kept as given.
- R8: A line-status read clears `overrun` and masks the head flags until the head changes. An overrun that arises in the same cycle as the read stays set.
- R9: Control bits 7:6 select the threshold: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. `trig_hit` is high exactly while `level` is at or above the selected threshold.
- R10: With control bit 0 low, the queue holds a single character and the threshold is 1.
- R11: After reset the queue is empty, `overrun` and `tx_flush` are low, queue mode is off and the threshold select is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Character-complete strobe from the deserializer |
| rx_byte | input | 8 | Received data byte |
| rx_par_err | input | 1 | Parity error flag of the character |
| rx_frm_err | input | 1 | Framing error flag of the character |
| rx_break | input | 1 | Break detected for the character |
| fcr_we | input | 1 | Control-word write strobe |
| fcr_wdata | input | 8 | Control word: bit 0 enable, bit 1 rx clear, bit 2 tx flush, bits 7:6 threshold |
| rbr_rd | input | 1 | Receive-buffer read strobe (pops the head) |
| lsr_rd | input | 1 | Line-status read strobe |
| rbr_q | output | 8 | Head data byte, 0x00 when empty |
| data_ready | output | 1 | Queue holds at least one character |
| overrun | output | 1 | Sticky overrun flag |
| head_par_err | output | 1 | Parity flag of the head character |
| head_frm_err | output | 1 | Framing flag of the head character |
| head_break | output | 1 | Break flag of the head character |
| err_in_fifo | output | 1 | Some stored character carries an error |
| level | output | 5 | Current occupancy |
| trig_hit | output | 1 | Occupancy at or above the selected threshold |
| tx_flush | output | 1 | One-cycle transmit-queue clear request |

## Verification
The bench fills the queue to exactly 16 and strobes a 17th character. A design that overwrote an entry or wrapped its pointers would return corrupted data during the drain that follows. A strobe coinciding with a read of a full queue is checked separately, because a design that tested fullness before the pop would flag a false overrun. Each threshold is crossed upward and then downward by one read, which exposes off-by-one comparisons. Errored characters are placed behind clean ones, so a design that showed queue-wide flags at the head, or that cleared the summary bit too early, would diverge from the model. Break characters, the single-character mode, line-status reads racing a new overrun, and clears racing a strobe round out the directed cases before a long seeded random run.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;

   localparam int RXF_DW = 8;

   typedef struct packed {
      logic              brk;
      logic              fe;
      logic              pe;
      logic [RXF_DW-1:0] data;
   } rxf_entry_t;

   // threshold select decode: 00->1, 01->4, 10->8, 11->14
   function automatic int unsigned rxf_threshold(input logic [1:0] sel);
      case (sel)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return 14;
      endcase
   endfunction

   function automatic logic rxf_has_err(input rxf_entry_t e);
      return e.brk | e.fe | e.pe;
   endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
   import uart_rxf_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int PTR_W = $clog2(DEPTH),
   parameter int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             pop,
   input  rxf_entry_t       wentry,
   output rxf_entry_t       head,
   output logic [CNT_W-1:0] cnt
);

   rxf_entry_t       mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !clr) mem[wr_ptr] <= wentry;
   end

   assign head = mem[rd_ptr];

endmodule

// File: rtl/rxf_errtrack.sv
module rxf_errtrack #(
   parameter int CNT_W = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic push,
   input  logic push_err,
   input  logic pop,
   input  logic head_err,
   input  logic head_change,
   input  logic nonempty,
   input  logic lsr_rd,
   input  logic ovr_set,
   output logic err_any,
   output logic ovr,
   output logic head_seen
);

   logic [CNT_W-1:0] err_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_cnt <= '0;
      end else if (clr) begin
         err_cnt <= '0;
      end else begin
         err_cnt <= err_cnt + CNT_W'(push & push_err) - CNT_W'(pop & head_err);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr       <= 1'b0;
         head_seen <= 1'b0;
      end else begin
         if (ovr_set)     ovr <= 1'b1;
         else if (lsr_rd) ovr <= 1'b0;

         if (head_change)            head_seen <= 1'b0;
         else if (lsr_rd && nonempty) head_seen <= 1'b1;
      end
   end

   assign err_any = (err_cnt != '0);

endmodule

// File: rtl/rxf_trigger.sv
module rxf_trigger
   import uart_rxf_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             en,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] cnt,
   output logic             hit
);

   logic [CNT_W-1:0] thr;

   always_comb begin
      if (en) thr = CNT_W'(rxf_threshold(sel));
      else    thr = CNT_W'(1);
   end

   assign hit = (cnt >= thr);

endmodule

// File: rtl/uart_rx_err_fifo.sv
module uart_rx_err_fifo
   import uart_rxf_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int PTR_W = $clog2(DEPTH),
   parameter int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [7:0]       rx_byte,
   input  logic             rx_par_err,
   input  logic             rx_frm_err,
   input  logic             rx_break,
   input  logic             fcr_we,
   input  logic [7:0]       fcr_wdata,
   input  logic             rbr_rd,
   input  logic             lsr_rd,
   output logic [7:0]       rbr_q,
   output logic             data_ready,
   output logic             overrun,
   output logic             head_par_err,
   output logic             head_frm_err,
   output logic             head_break,
   output logic             err_in_fifo,
   output logic [CNT_W-1:0] level,
   output logic             trig_hit,
   output logic             tx_flush
);

   generate
      if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 16");
      end
      if (CNT_W != PTR_W + 1) begin : g_bad_cnt
         $error("CNT_W must be one wider than PTR_W");
      end
   endgenerate

   logic             en_q;
   logic [1:0]       sel_q;
   logic             txf_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cap;
   logic             clr, nonempty, room;
   logic             do_push, do_pop, ovr_set, head_change;
   logic             head_seen;
   rxf_entry_t       wentry, head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= 2'b00;
         txf_q <= 1'b0;
      end else begin
         txf_q <= fcr_we & fcr_wdata[2];
         if (fcr_we) begin
            en_q  <= fcr_wdata[0];
            sel_q <= fcr_wdata[7:6];
         end
      end
   end

   assign cap         = en_q ? CNT_W'(DEPTH) : CNT_W'(1);
   assign clr         = fcr_we & (fcr_wdata[1] | (fcr_wdata[0] != en_q));
   assign nonempty    = (cnt != '0);
   assign room        = (cnt < cap);
   assign do_pop      = rbr_rd & nonempty & ~clr;
   assign do_push     = rx_valid & ~clr & (room | do_pop);
   assign ovr_set     = rx_valid & ~clr & ~room & ~do_pop;
   assign head_change = clr | do_pop | (do_push & ~nonempty);

   always_comb begin
      wentry.brk  = rx_break;
      wentry.fe   = rx_frm_err | rx_break;
      wentry.pe   = rx_par_err;
      wentry.data = rx_break ? '0 : rx_byte;
   end

   rxf_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .push   (do_push),
      .pop    (do_pop),
      .wentry (wentry),
      .head   (head),
      .cnt    (cnt)
   );

   rxf_errtrack #(.CNT_W(CNT_W)) u_err (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .push        (do_push),
      .push_err    (rxf_has_err(wentry)),
      .pop         (do_pop),
      .head_err    (rxf_has_err(head)),
      .head_change (head_change),
      .nonempty    (nonempty),
      .lsr_rd      (lsr_rd),
      .ovr_set     (ovr_set),
      .err_any     (err_in_fifo),
      .ovr         (overrun),
      .head_seen   (head_seen)
   );

   rxf_trigger #(.CNT_W(CNT_W)) u_trig (
      .en  (en_q),
      .sel (sel_q),
      .cnt (cnt),
      .hit (trig_hit)
   );

   assign level        = cnt;
   assign data_ready   = nonempty;
   assign rbr_q        = nonempty ? head.data : 8'h00;
   assign head_par_err = nonempty & ~head_seen & head.pe;
   assign head_frm_err = nonempty & ~head_seen & head.fe;
   assign head_break   = nonempty & ~head_seen & head.brk;
   assign tx_flush     = txf_q;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             fcr_we,
   input logic [7:0]       fcr_wdata,
   input logic             rbr_rd,
   input logic             lsr_rd,
   input logic [7:0]       rbr_q,
   input logic             data_ready,
   input logic             overrun,
   input logic             head_par_err,
   input logic             head_frm_err,
   input logic             head_break,
   input logic             err_in_fifo,
   input logic [CNT_W-1:0] level,
   input logic             trig_hit,
   input logic             tx_flush,
   input logic             en_q
);

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH)); // R1

   AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && level == CNT_W'(DEPTH) && !rbr_rd && !fcr_we
      |=> overrun && level == CNT_W'(DEPTH)); // R2

   AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      fcr_we && fcr_wdata[1] |=> level == '0); // R3

   AST_TX_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fcr_we && fcr_wdata[2] |=> tx_flush); // R3

   AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      level == '0 |-> rbr_q == 8'h00 && !data_ready
                      && !head_par_err && !head_frm_err && !head_break); // R4

   AST_HEAD_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
      (head_par_err || head_frm_err || head_break) |-> err_in_fifo); // R6

   AST_BREAK_IMPLIES_FE: assert property (@(posedge clk) disable iff (!rst_n)
      head_break |-> head_frm_err && rbr_q == 8'h00); // R7

   AST_LSR_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_rd && !rx_valid |=> !overrun); // R8

   AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      trig_hit |-> data_ready); // R9

   AST_SINGLE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> level <= CNT_W'(1)); // R10

endmodule

bind uart_rx_err_fifo rxf_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_valid     (rx_valid),
   .fcr_we       (fcr_we),
   .fcr_wdata    (fcr_wdata),
   .rbr_rd       (rbr_rd),
   .lsr_rd       (lsr_rd),
   .rbr_q        (rbr_q),
   .data_ready   (data_ready),
   .overrun      (overrun),
   .head_par_err (head_par_err),
   .head_frm_err (head_frm_err),
   .head_break   (head_break),
   .err_in_fifo  (err_in_fifo),
   .level        (level),
   .trig_hit     (trig_hit),
   .tx_flush     (tx_flush),
   .en_q         (en_q)
);

// File: tb/sim_uart_rx_err_fifo.sv
`timescale 1ns/1ps
module sim_uart_rx_err_fifo;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_break = 1'b0;
   logic       fcr_we = 1'b0;
   logic [7:0] fcr_wdata = '0;
   logic       rbr_rd = 1'b0, lsr_rd = 1'b0;
   logic [7:0] rbr_q;
   logic       data_ready, overrun, head_par_err, head_frm_err, head_break;
   logic       err_in_fifo, trig_hit, tx_flush;
   logic [4:0] level;

   always #5 clk = ~clk;

   uart_rx_err_fifo u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_break(rx_break),
      .fcr_we(fcr_we), .fcr_wdata(fcr_wdata), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
      .rbr_q(rbr_q), .data_ready(data_ready), .overrun(overrun),
      .head_par_err(head_par_err), .head_frm_err(head_frm_err),
      .head_break(head_break), .err_in_fifo(err_in_fifo), .level(level),
      .trig_hit(trig_hit), .tx_flush(tx_flush)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   string phase   = "R11 reset";

   // reference model: entry = {brk, fe, pe, data}
   logic [10:0] mq[$];
   bit          m_en = 0, m_ovr = 0, m_seen = 0, m_txf = 0;
   bit [1:0]    m_sel = 0;

   function automatic int thr_of(bit en, bit [1:0] sel);
      if (!en) return 1;
      case (sel)
         2'd0: return 1;
         2'd1: return 4;
         2'd2: return 8;
         default: return 14;
      endcase
   endfunction

   function automatic bit any_err();
      foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1;
      return 0;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s [%s]: got %0h expected %0h", tag, phase, act, exp);
      end
   endtask

   task automatic check_all();
      int sz = mq.size();
      int hf = (sz > 0 && !m_seen) ? int'(mq[0][10:8]) : 0;
      chk("R1 level", level, sz);
      chk("R4 data_ready", data_ready, sz > 0);
      chk("R4 rbr_q", rbr_q, sz > 0 ? int'(mq[0][7:0]) : 0);
      chk("R5 head flags", {head_break, head_frm_err, head_par_err}, hf);
      chk("R6 err_in_fifo", err_in_fifo, any_err());
      chk("R2 overrun", overrun, m_ovr);
      chk("R9 trig_hit", trig_hit, sz >= thr_of(m_en, m_sel));
      chk("R3 tx_flush", tx_flush, m_txf);
   endtask

   task automatic model(input bit v, input bit [7:0] d, input bit pe, input bit fe,
                        input bit brk, input bit we, input bit [7:0] wd,
                        input bit rr, input bit lr);
      int  cap = m_en ? 16 : 1;
      int  sz  = mq.size();
      bit  clr = we && (wd[1] || (wd[0] != m_en));
      bit  pop = rr && sz > 0 && !clr;
      bit  push = v && !clr && (sz < cap || pop);
      bit  oset = v && !clr && sz >= cap && !pop;
      bit  hchg = clr || pop || (push && sz == 0);
      if (hchg) m_seen = 0;
      else if (lr && sz > 0) m_seen = 1;
      if (oset) m_ovr = 1;
      else if (lr) m_ovr = 0;
      if (pop) void'(mq.pop_front());
      if (push) mq.push_back(brk ? {1'b1, 1'b1, pe, 8'h00} : {1'b0, fe, pe, d});
      if (clr) mq.delete();
      m_txf = we && wd[2];
      if (we) begin
         m_en  = wd[0];
         m_sel = wd[7:6];
      end
   endtask

   // drive at the falling edge, let one rising edge act, check at the next fall
   task automatic step(input bit v, input bit [7:0] d, input bit pe, input bit fe,
                       input bit brk, input bit we, input bit [7:0] wd,
                       input bit rr, input bit lr);
      rx_valid = v; rx_byte = d; rx_par_err = pe; rx_frm_err = fe; rx_break = brk;
      fcr_we = we; fcr_wdata = wd; rbr_rd = rr; lsr_rd = lr;
      model(v, d, pe, fe, brk, we, wd, rr, lr);
      @(negedge clk);
      rx_valid = 0; fcr_we = 0; rbr_rd = 0; lsr_rd = 0;
      check_all();
   endtask

   task automatic put(input bit [7:0] d, input bit pe, input bit fe, input bit brk);
      step(1, d, pe, fe, brk, 0, 0, 0, 0);
   endtask
   task automatic rd();   step(0, 0, 0, 0, 0, 0, 0, 1, 0); endtask
   task automatic lsr();  step(0, 0, 0, 0, 0, 0, 0, 0, 1); endtask
   task automatic ctl(input bit [7:0] wd); step(0, 0, 0, 0, 0, 1, wd, 0, 0); endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog [%s]: got timeout expected completion", phase);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      phase = "R11 reset";
      check_all();

      phase = "R10 single mode";
      put(8'h11, 0, 0, 0);
      put(8'h22, 0, 0, 0);          // second char overruns at depth 1
      lsr();
      rd();

      phase = "R1 fill to 16";
      ctl(8'hC1);                   // enable, threshold 14
      for (int i = 0; i < 16; i++) put(8'(8'h30 + i), i == 9, i == 12, 0);
      phase = "R2 17th char discarded";
      put(8'hEE, 1, 1, 0);
      phase = "R2 read plus write at full";
      step(1, 8'h77, 0, 0, 0, 0, 0, 1, 0);
      phase = "R8 lsr read with new overrun";
      step(1, 8'h78, 0, 0, 0, 0, 0, 0, 1);
      lsr();
      phase = "R5 drain with head flags";
      for (int i = 0; i < 16; i++) begin
         if (i % 3 == 0) lsr();
         rd();
      end
      phase = "R4 empty read";
      rd();
      rd();

      phase = "R7 break storage";
      put(8'hA5, 0, 0, 1);
      put(8'h5A, 1, 0, 1);
      lsr();
      rd();
      rd();

      phase = "R9 thresholds";
      for (int s = 0; s < 4; s++) begin
         ctl({2'(s), 6'b000001});
         for (int k = 1; k < thr_of(1, 2'(s)); k++) put(8'(k), 0, 0, 0);
         put(8'h55, 0, 0, 0);
         rd();
         ctl({2'(s), 6'b000011});
      end

      phase = "R3 clear versus strobe";
      for (int i = 0; i < 5; i++) put(8'(i), 0, 1, 0);
      ctl(8'h05);                   // tx flush only
      step(1, 8'h99, 0, 0, 0, 1, 8'h03, 0, 0);
      ctl(8'h01);
      put(8'h10, 0, 0, 0);
      ctl(8'h00);                   // enable change clears

      phase = "random";
      ctl(8'h81);
      for (int n = 0; n < 4000; n++) begin
         int r = int'($urandom_range(0, 99));
         bit v  = r < 45;
         bit rr = ($urandom_range(0, 99) < 38);
         bit lr = ($urandom_range(0, 99) < 15);
         bit we = ($urandom_range(0, 199) == 0);
         bit [7:0] wd = {2'($urandom_range(0, 3)), 3'b000,
                         ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0),
                         ($urandom_range(0, 7) != 0)};
         step(v, 8'($urandom), $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
              $urandom_range(0, 19) == 0, we, wd, rr, lr);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule